// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a fast reference clock into the two timing strobes a UART needs: a sample strobe at sixteen (or eight, or four) times the bit rate for the receiver, and a bit strobe at the bit rate for the transmitter. The sample period is set by a 16-bit integer divisor plus a 4-bit fraction counted in sixteenths of a reference cycle. A small accumulator spreads the fraction so that, over any run of sixteen sample periods, exactly FRACT of them are one reference cycle longer than the rest. The divisor for a wanted rate is the reference frequency over sixteen times the baud rate, split into its integer part and sixteen times its remainder, rounded. For example, a 28.23 MHz reference and 190 kbaud give an integer of 9 and a fraction of 5.

A double-rate mode and a quad-rate mode cut the number of sample strobes per bit from 16 to 8 or 4. This lets the data rate go above what a 16x scheme allows from the same reference. In 1x mode the receiver is expected to vote over three samples near mid-bit. That vote is outside this block, which only provides the strobes. Settings that must not be used are rejected and reported on a flag.

All inputs are plain control levels, sampled on the reference clock. The two outputs are single-cycle strobes with no handshake: a strobe can be neither held off nor stalled, so a consumer must take it in the cycle it is high.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low both strobes are low and the fraction accumulator and the sample count are zero. With a legal divisor, the first `sample_tick` is high in the cycle that follows the first rising clock edge after `rst_n` goes high.
- R2: With `frac` = 0 in 1x mode (`mode_x2` = 0, `mode_x4` = 0), `sample_tick` pulses once every `div_int` reference cycles, and each pulse lasts one cycle.
- R3: The accumulator starts at 0. At each sample strobe it adds `frac` modulo 16, and on a carry out of bit 3 the period that starts at that strobe lasts `div_int`+1 cycles instead of `div_int`. As a result, any 16 consecutive periods include exactly `frac` long ones.
- R4: With `mode_x2` = 1 and `mode_x4` = 0, `bit_tick` fires on every 8th `sample_tick`, the first one on the 8th strobe after reset.
- R5: With `mode_x4` = 1 and `mode_x2` = 0, `bit_tick` fires on every 4th `sample_tick`. In 1x mode it fires on every 16th.
- R6: If `mode_x2` and `mode_x4` are both 1, the block runs in 4x mode and `config_error` is 1.
- R7: If `div_int[7:0]` is zero, `config_error` is 1, no strobe is produced, and the counters return to their reset state. Once the setting is legal again, the next `sample_tick` comes one cycle later.
- R8: A change to `div_int` or `frac` made during a period never changes the length of that period. The new value applies from the next `sample_tick` on.
- R9: `bit_tick` is never high in a cycle where `sample_tick` is low.
- R10: With `div_int` = 9 and `frac` = 5 (the 28.23 MHz / 190 kbaud setting), the first 16 periods after reset add up to 149 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_int | input | 16 | Integer divisor; low byte must be nonzero |
| frac | input | 4 | Fractional divisor in sixteenths |
| mode_x2 | input | 1 | Double-rate mode (8 samples per bit) |
| mode_x4 | input | 1 | Quad-rate mode (4 samples per bit); wins if both set |
| sample_tick | output | 1 | One-cycle oversampling strobe for the receiver |
| bit_tick | output | 1 | One-cycle bit-rate strobe for the transmitter |
| config_error | output | 1 | Illegal setting: zero divisor low byte or both rate modes set |

## Verification
The hardest case to reach is a divisor change that lands strictly inside a running period. An ordinary test only sets the divisor while the block is idle or in reset, so it never sees whether the new value cuts short the period already in progress. The stimulus therefore waits for a sample strobe under a long divisor, and a few cycles later drops the divisor to a short one. It then measures the next two gaps, expecting the old length followed by the new one. The full fraction pattern is a second case that is hard to see: the carries only repeat after sixteen periods. Each table vector therefore runs for 48 strobes and compares every gap against a model accumulator kept in the bench.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  typedef enum logic [1:0] {RATE_1X = 2'd0, RATE_2X = 2'd1, RATE_4X = 2'd2} rate_e;

  localparam int unsigned OSR_1X = 16;
  localparam int unsigned OSR_2X = 8;
  localparam int unsigned OSR_4X = 4;
  localparam int unsigned SUB_W  = $clog2(OSR_1X);

  function automatic logic [SUB_W-1:0] osr_last(input rate_e r);
    case (r)
      RATE_2X: osr_last = SUB_W'(OSR_2X - 1);
      RATE_4X: osr_last = SUB_W'(OSR_4X - 1);
      default: osr_last = SUB_W'(OSR_1X - 1);
    endcase
  endfunction
endpackage

// File: rtl/fbg_cfg_check.sv
module fbg_cfg_check
  import frac_baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned LSB_W = 8
) (
  input  logic [DIV_W-1:0] div_int,
  input  logic             mode_x2,
  input  logic             mode_x4,
  output rate_e            rate,
  output logic             lsb_zero,
  output logic             both_modes
);
  always_comb begin
    lsb_zero   = (div_int[LSB_W-1:0] == '0);
    both_modes = mode_x2 & mode_x4;
    if (mode_x4)      rate = RATE_4X;
    else if (mode_x2) rate = RATE_2X;
    else              rate = RATE_1X;
  end
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] frac,
  output logic              boundary,
  output logic              tick_o
);
  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;
  logic              carry;

  always_comb begin
    acc_sum  = {1'b0, acc} + {1'b0, frac};
    carry    = acc_sum[FRAC_W];
    boundary = run && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt    <= '0;
      acc    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= boundary;
      if (boundary) begin
        acc <= acc_sum[FRAC_W-1:0];
        cnt <= carry ? div_int : div_int - 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) || !$past(run)); // R8

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(div_int) >= 2 && run) |=> !tick_o); // R2

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !tick_o); // R7
endmodule

// File: rtl/fbg_bit_tick.sv
module fbg_bit_tick
  import frac_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             boundary,
  input  logic [SUB_W-1:0] last_idx,
  output logic             bit_o
);
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sub   <= '0;
      bit_o <= 1'b0;
    end else if (boundary) begin
      if (sub >= last_idx) begin
        sub   <= '0;
        bit_o <= 1'b1;
      end else begin
        sub   <= sub + 1'b1;
        bit_o <= 1'b0;
      end
    end else begin
      bit_o <= 1'b0;
    end
  end

  AST_BIT_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o |-> $past(boundary)); // R9
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned LSB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] frac,
  input  logic              mode_x2,
  input  logic              mode_x4,
  output logic              sample_tick,
  output logic              bit_tick,
  output logic              config_error
);
  rate_e            rate;
  logic             lsb_zero;
  logic             both_modes;
  logic             run;
  logic             boundary;
  logic [SUB_W-1:0] last_idx;

  fbg_cfg_check #(.DIV_W(DIV_W), .LSB_W(LSB_W)) u_cfg (
    .div_int    (div_int),
    .mode_x2    (mode_x2),
    .mode_x4    (mode_x4),
    .rate       (rate),
    .lsb_zero   (lsb_zero),
    .both_modes (both_modes)
  );

  assign run          = !lsb_zero;
  assign last_idx     = osr_last(rate);
  assign config_error = lsb_zero | both_modes;

  fbg_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_int  (div_int),
    .frac     (frac),
    .boundary (boundary),
    .tick_o   (sample_tick)
  );

  fbg_bit_tick u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .boundary (boundary),
    .last_idx (last_idx),
    .bit_o    (bit_tick)
  );

  AST_BIT_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R9

  AST_BOTH_MODES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_x2 && mode_x4) |-> config_error); // R6
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_int = 16'd4;
  logic [3:0]  frac = 4'd0;
  logic        mode_x2 = 1'b0;
  logic        mode_x4 = 1'b0;
  logic        sample_tick, bit_tick, config_error;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  localparam int NV = 7;
  localparam int NT = 48;
  localparam int V_DIV [NV] = '{9, 4, 7, 3, 5, 258, 1};
  localparam int V_FRC [NV] = '{5, 0, 11, 15, 3, 8, 15};
  localparam bit V_X2  [NV] = '{0, 0, 1, 0, 1, 0, 0};
  localparam bit V_X4  [NV] = '{0, 0, 0, 1, 1, 0, 1};
  localparam bit V_ERR [NV] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int V_OSR [NV] = '{16, 16, 8, 4, 4, 16, 4};
  localparam string V_TAG [NV] = '{"R3", "R2", "R4", "R5", "R6", "R3", "R5"};

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .frac(frac),
    .mode_x2(mode_x2), .mode_x4(mode_x4),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .config_error(config_error)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input int v);
    int acc = 0, ti = 0, cyc = 0, last = 0, nxt = 0, first = -1;
    int gap_bad = 0, bit_bad = 0, orphan = 0, sum16 = 0;
    div_int = 16'(V_DIV[v]); frac = 4'(V_FRC[v]);
    mode_x2 = V_X2[v]; mode_x4 = V_X4[v];
    do_reset();
    chk(config_error == V_ERR[v], V_TAG[v], config_error, V_ERR[v]);
    while (ti < NT && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (bit_tick && !sample_tick) orphan++;
      if (sample_tick) begin
        if (ti == 0) first = cyc;
        else begin
          if (cyc - last != nxt) gap_bad++;
          if (ti <= 16) sum16 += cyc - last;
        end
        if (bit_tick != (((ti + 1) % V_OSR[v]) == 0)) bit_bad++;
        nxt = V_DIV[v] + (((acc + V_FRC[v]) >= 16) ? 1 : 0);
        acc = (acc + V_FRC[v]) % 16;
        last = cyc;
        ti++;
      end
    end
    chk(ti == NT, V_TAG[v], ti, NT);
    chk(first == 1, "R1 first tick", first, 1);
    chk(gap_bad == 0, V_TAG[v], gap_bad, 0);
    chk(bit_bad == 0, V_TAG[v], bit_bad, 0);
    chk(orphan == 0, "R9", orphan, 0);
    chk(sum16 == 16 * V_DIV[v] + V_FRC[v], "R3 window", sum16, 16 * V_DIV[v] + V_FRC[v]);
    if (v == 0) chk(sum16 == 149, "R10", sum16, 149);
  endtask

  initial begin
    int cnt, g1, g2, lst;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(sample_tick == 1'b0, "R1 reset sample", sample_tick, 0);
    chk(bit_tick == 1'b0, "R1 reset bit", bit_tick, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R7: zero low byte stops everything
    div_int = 16'h0100; frac = 4'd7; mode_x2 = 0; mode_x4 = 0;
    do_reset();
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) cnt++;
    end
    chk(cnt == 0, "R7 no ticks", cnt, 0);
    chk(config_error == 1'b1, "R7 flag", config_error, 1);
    div_int = 16'h0101;
    @(negedge clk);
    chk(sample_tick == 1'b1, "R7 resume", sample_tick, 1);
    chk(config_error == 1'b0, "R7 flag clear", config_error, 0);

    // R8: divisor change mid-period
    div_int = 16'd20; frac = 4'd0;
    do_reset();
    @(negedge clk);
    chk(sample_tick == 1'b1, "R8 start", sample_tick, 1);
    repeat (5) @(negedge clk);
    div_int = 16'd3;
    cnt = 5; g1 = 0; g2 = 0; lst = 0;
    while (g2 == 0 && cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (sample_tick) begin
        if (g1 == 0) g1 = cnt; else g2 = cnt - g1;
      end
    end
    chk(g1 == 20, "R8 old period kept", g1, 20);
    chk(g2 == 3, "R8 new period", g2, 3);

    // R6: both modes flagged without reset
    mode_x2 = 1; mode_x4 = 1;
    #1;
    chk(config_error == 1'b1, "R6 flag", config_error, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule